// File: doc/BRIEF.md
# Multi-Port Boot Load Controller

This block sequences a processor's boot immediately after reset. A strap input is captured while reset is held. When the captured strap is low, the block requests a master-mode boot from another engine and takes no further part. When it is high, the block waits on one host port and a set of link ports, all of which listen from the moment reset is released. The first port to present a valid word becomes the boot source.

The block then stores a fixed number of words from that source into the bottom of an internal memory, at ascending addresses starting from zero. After the final word it pulses a completion interrupt. On the next cycle it raises a core-release output, which tells the core to start fetching at address zero. Activity on every other port is ignored until the next reset. A status output gives the sequencer state and the index of the chosen source.

Top module: `boot_seq_ctrl`

## Requirements
- R1: The strap is sampled on every clock edge while `rst_n` is low, and the value present at the last such edge is the one used. If it is high, `state_o` reads 1 (idle wait) from the first cycle after reset is released, and `master_boot_start` stays low.
- R2: If the sampled strap is low, `master_boot_start` goes high from the first cycle after reset is released and stays high. `state_o` stays 0. `mem_we` never asserts, whatever the host and link ports present.
- R3: In idle wait, the first cycle with any valid input selects the source. The host port wins over every link port, and among link ports the lowest number wins. On `src_idx_o`, code 0 means the host port and code i+1 means link port i. The word presented on that cycle is written to address 0, and `state_o` reads 2 (loading) from the next cycle.
- R4: Boot words are written to addresses 0, 1, 2 and so on up to LOAD_WORDS-1 in that order. Each written word is the data on the selected port in its valid cycle.
- R5: `mem_we` is high only on cycles where the selected port is valid, in idle wait or loading. Valid words on non-selected ports, and on any port after completion, cause no write.
- R6: `done_irq` is high for exactly one cycle, the cycle after the edge that writes the last word. `state_o` reads 3 (done) from that same cycle.
- R7: `core_release` rises on the cycle after `done_irq` and stays high until the next reset.
- R8: While reset is held, `state_o` is 0 and `done_irq`, `core_release`, `master_boot_start` and `mem_we` are low. A new boot after reset starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_strap | input | 1 | Boot-mode strap (1 = wait for host/link boot) |
| host_valid | input | 1 | Host port word valid |
| host_data | input | DATA_W | Host port word |
| link_valid | input | NUM_LINKS | Per-link word valid |
| link_data | input | NUM_LINKS*DATA_W | Link words, link i in slice i |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | ADDR_W | Internal memory write address |
| mem_wdata | output | DATA_W | Internal memory write data |
| done_irq | output | 1 | One-cycle completion interrupt |
| core_release | output | 1 | Core may fetch from address zero |
| master_boot_start | output | 1 | Request for master-mode boot |
| state_o | output | 2 | 0 reset/master, 1 idle wait, 2 loading, 3 done |
| src_idx_o | output | SRC_W | Selected source (0 host, i+1 link i) |

## Verification
The bench builds the block with four link ports, 16-bit words and LOAD_WORDS set to 16. This keeps every load short, so a single run can complete a full boot from each priority pattern and still cover the final-word interrupt and the release timing. With four links, the encoding is exercised up to its top code 4. The vector table includes simultaneous arrivals from the host and from pairs of links. Directed runs cover a strap that changes during reset, master mode with busy ports, and a boot repeated after a reset.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BS_RESET = 2'd0,
    BS_WAIT  = 2'd1,
    BS_LOAD  = 2'd2,
    BS_DONE  = 2'd3
  } boot_state_e;

  // Source code carried by a link port: host owns code 0.
  function automatic int unsigned link_src_code(int unsigned link_num);
    return link_num + 1;
  endfunction

  // True when the word about to be written is the final one of the load.
  function automatic logic is_final_word(int unsigned count, int unsigned total);
    return count == total - 1;
  endfunction

endpackage

// File: rtl/boot_src_arbiter.sv
module boot_src_arbiter #(
  parameter int NUM_LINKS = 4,
  parameter int SRC_W     = 3
) (
  input  logic                 host_req,
  input  logic [NUM_LINKS-1:0] link_req,
  output logic                 any_req,
  output logic [SRC_W-1:0]     win_idx
);
  import boot_seq_pkg::*;

  always_comb begin
    win_idx = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (link_req[i]) win_idx = SRC_W'(link_src_code(i));
    end
    if (host_req) win_idx = '0;
    any_req = host_req | (|link_req);
  end

endmodule

// File: rtl/boot_port_mux.sv
module boot_port_mux #(
  parameter int NUM_LINKS = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = 3
) (
  input  logic [SRC_W-1:0]            sel_idx,
  input  logic                        host_valid,
  input  logic [DATA_W-1:0]           host_data,
  input  logic [NUM_LINKS-1:0]        link_valid,
  input  logic [NUM_LINKS*DATA_W-1:0] link_data,
  output logic                        sel_valid,
  output logic [DATA_W-1:0]           sel_data
);
  localparam int NUM_PORTS = NUM_LINKS + 1;

  logic              port_valid [NUM_PORTS];
  logic [DATA_W-1:0] port_data  [NUM_PORTS];

  assign port_valid[0] = host_valid;
  assign port_data[0]  = host_data;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    assign port_valid[g+1] = link_valid[g];
    assign port_data[g+1]  = link_data[g*DATA_W +: DATA_W];
  end

  always_comb begin
    sel_valid = 1'b0;
    sel_data  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_idx == SRC_W'(p)) begin
        sel_valid = port_valid[p];
        sel_data  = port_data[p];
      end
    end
  end

endmodule

// File: rtl/boot_word_counter.sv
module boot_word_counter #(
  parameter int LOAD_WORDS = 256,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [ADDR_W-1:0] count,
  output logic              last_word
);
  import boot_seq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= last_word ? '0 : count + 1'b1;
  end

  assign last_word = is_final_word(int'(count), LOAD_WORDS);

  // R4: each accepted non-final word advances the address by exactly one
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !last_word) |=> (count == $past(count) + 1'b1));

  // R4: without a write the address holds
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count));

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
  parameter int NUM_LINKS  = 4,
  parameter int DATA_W     = 32,
  parameter int LOAD_WORDS = 256,
  parameter int ADDR_W     = (LOAD_WORDS > 1) ? $clog2(LOAD_WORDS) : 1,
  parameter int SRC_W      = $clog2(NUM_LINKS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        boot_strap,
  input  logic                        host_valid,
  input  logic [DATA_W-1:0]           host_data,
  input  logic [NUM_LINKS-1:0]        link_valid,
  input  logic [NUM_LINKS*DATA_W-1:0] link_data,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic                        done_irq,
  output logic                        core_release,
  output logic                        master_boot_start,
  output logic [1:0]                  state_o,
  output logic [SRC_W-1:0]            src_idx_o
);
  import boot_seq_pkg::*;

  boot_state_e       state;
  logic              strap_q;
  logic              master_q;
  logic [SRC_W-1:0]  src_q;

  // Named internal events used by the assertions
  logic              any_req;
  logic [SRC_W-1:0]  win_idx;
  logic [SRC_W-1:0]  mux_sel;
  logic              sel_valid;
  logic              capture_on;
  logic              wr_fire;
  logic              last_word;
  logic              load_finish;

  boot_src_arbiter #(.NUM_LINKS(NUM_LINKS), .SRC_W(SRC_W)) u_arb (
    .host_req (host_valid),
    .link_req (link_valid),
    .any_req  (any_req),
    .win_idx  (win_idx)
  );

  assign mux_sel = (state == BS_WAIT) ? win_idx : src_q;

  boot_port_mux #(.NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_mux (
    .sel_idx    (mux_sel),
    .host_valid (host_valid),
    .host_data  (host_data),
    .link_valid (link_valid),
    .link_data  (link_data),
    .sel_valid  (sel_valid),
    .sel_data   (mem_wdata)
  );

  assign capture_on  = (state == BS_WAIT) || (state == BS_LOAD);
  assign wr_fire     = capture_on && sel_valid;
  assign load_finish = wr_fire && last_word;

  boot_word_counter #(.LOAD_WORDS(LOAD_WORDS), .ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (wr_fire),
    .count     (mem_addr),
    .last_word (last_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= BS_RESET;
      strap_q      <= boot_strap;
      master_q     <= 1'b0;
      src_q        <= '0;
      done_irq     <= 1'b0;
      core_release <= 1'b0;
    end else begin
      done_irq     <= load_finish;
      core_release <= core_release | done_irq;
      case (state)
        BS_RESET: if (!master_q) begin
          if (strap_q) state <= BS_WAIT;
          else         master_q <= 1'b1;
        end
        BS_WAIT: if (wr_fire) begin
          src_q <= win_idx;
          state <= last_word ? BS_DONE : BS_LOAD;
        end
        BS_LOAD: if (load_finish) state <= BS_DONE;
        default: ;
      endcase
    end
  end

  assign mem_we            = wr_fire;
  assign master_boot_start = master_q;
  assign state_o           = state;
  assign src_idx_o         = src_q;

  // R6: the completion interrupt lasts a single cycle
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R6: the interrupt coincides with the done state
  assert_irq_in_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (state == BS_DONE));

  // R7: release is sticky until reset
  assert_release_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_release |=> core_release);

  // R7: release only follows the interrupt
  assert_release_after_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_release) |-> $past(done_irq));

  // R5: a write always has a valid port behind it
  assert_we_has_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (host_valid || (|link_valid)));

  // R2: master mode never touches memory
  assert_master_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_boot_start |-> (!mem_we && state == BS_RESET));

  // R3: the chosen source cannot change while loading
  assert_src_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_LOAD) |=> $stable(src_q));

  // R5: nothing is written once done
  assert_no_write_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_DONE) |-> !mem_we);

endmodule

// File: tb/boot_seq_ctrl_test.sv
`timescale 1ns/1ps
module boot_seq_ctrl_test;
  localparam int NL  = 4;
  localparam int DW  = 16;
  localparam int LW  = 16;
  localparam int AW  = $clog2(LW);
  localparam int SW  = $clog2(NL + 1);
  localparam int NV  = 6;

  // Request pattern: bit 0 = host, bit i+1 = link i; expected source code
  localparam logic [NL:0] VEC_REQ [NV] = '{5'b00001, 5'b00010, 5'b10000,
                                           5'b01001, 5'b10100, 5'b11000};
  localparam int          VEC_EXP [NV] = '{0, 1, 4, 0, 2, 3};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              boot_strap = 1'b0;
  logic              host_valid = 1'b0;
  logic [DW-1:0]     host_data = '0;
  logic [NL-1:0]     link_valid = '0;
  logic [NL*DW-1:0]  link_data = '0;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wdata;
  logic              done_irq;
  logic              core_release;
  logic              master_boot_start;
  logic [1:0]        state_o;
  logic [SW-1:0]     src_idx_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  boot_seq_ctrl #(.NUM_LINKS(NL), .DATA_W(DW), .LOAD_WORDS(LW)) uut (
    .clk, .rst_n, .boot_strap, .host_valid, .host_data, .link_valid, .link_data,
    .mem_we, .mem_addr, .mem_wdata, .done_irq, .core_release,
    .master_boot_start, .state_o, .src_idx_o
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s, input int p, input int k);
    return DW'(s * 4096 + p * 256 + k);
  endfunction

  task automatic drive_ports(input int s, input int k, input logic [NL:0] vmask);
    host_valid = vmask[0];
    host_data  = pat(s, 0, k);
    for (int i = 0; i < NL; i++) begin
      link_valid[i] = vmask[i+1];
      link_data[i*DW +: DW] = pat(s, i + 1, k);
    end
  endtask

  // R8 and R1: hold reset, check reset outputs, set strap late, release
  task automatic do_reset(input bit strap_early, input bit strap_late);
    @(negedge clk);
    rst_n = 1'b0;
    boot_strap = strap_early;
    drive_ports(0, 0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(state_o == 2'd0 && !done_irq && !core_release && !master_boot_start && !mem_we,
        "R8 reset outputs", {state_o, done_irq, core_release, master_boot_start, mem_we}, 0);
    boot_strap = strap_late;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    boot_strap = ~strap_late;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_scenario(input int s);
    logic [NL:0] sel_bit;
    int e;
    e = VEC_EXP[s];
    sel_bit = (NL+1)'(1) << e;
    do_reset(1'b1, 1'b1);
    chk(state_o == 2'd1 && !master_boot_start, "R1 idle wait", state_o, 1);
    #1 chk(!mem_we, "R5 no write while idle", mem_we, 0);
    @(posedge clk);
    for (int k = 0; k < LW; k++) begin
      @(negedge clk);
      if (k == 1) chk(state_o == 2'd2 && src_idx_o == SW'(e), "R3 loading source",
                      int'(src_idx_o), e);
      if (k == 5) begin
        drive_ports(s, k, ~sel_bit);
        #1 chk(!mem_we, "R5 other ports ignored", mem_we, 0);
        @(posedge clk);
        @(negedge clk);
      end
      if (k == 0) drive_ports(s, k, VEC_REQ[s]);
      else        drive_ports(s, k, '1);
      #1 chk(mem_we && mem_addr == AW'(k) && mem_wdata == pat(s, e, k),
             (k == 0) ? "R3 first word" : "R4 word write",
             {mem_we, mem_addr, mem_wdata}, {1'b1, AW'(k), pat(s, e, k)});
      @(posedge clk);
    end
    @(negedge clk);
    drive_ports(s, LW, ~sel_bit);
    chk(done_irq && state_o == 2'd3 && !core_release, "R6 irq with done",
        {done_irq, state_o, core_release}, 4'b1110);
    #1 chk(!mem_we, "R5 no write after done", mem_we, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done_irq && core_release, "R7 release after irq", {done_irq, core_release}, 2'b01);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(core_release && !done_irq, "R7 release held", core_release, 1);
  endtask

  initial begin
    // Table-driven boots across priority patterns
    for (int s = 0; s < NV; s++) run_scenario(s);

    // R1: strap low early, high at the final reset edge -> idle wait
    do_reset(1'b0, 1'b1);
    chk(state_o == 2'd1 && !master_boot_start, "R1 late strap sample", state_o, 1);

    // R2: strap high early, low at final edge -> master mode, busy ports ignored
    do_reset(1'b1, 1'b0);
    chk(master_boot_start && state_o == 2'd0, "R2 master start",
        {master_boot_start, state_o}, 3'b100);
    for (int k = 0; k < 4; k++) begin
      drive_ports(9, k, '1);
      #1 chk(!mem_we, "R2 no write in master mode", mem_we, 0);
      @(posedge clk);
      @(negedge clk);
      chk(master_boot_start && state_o == 2'd0, "R2 master held",
          {master_boot_start, state_o}, 3'b100);
    end

    // R8: a fresh boot after reset restarts at address 0
    run_scenario(2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule